// File: doc/BRIEF.md
# Bandwidth usage monitoring unit

This block counts the traffic that passes a monitoring point and keeps one counter for each monitoring ID. Software issues a command through a single control word that carries an opcode, a monitor ID, an event code, an access type and an access-type-valid flag. There are two commands. The first selects what a monitor's counter counts. The second copies one counter, with its overflow and invalid flags, into a snapshot register that software can read.

A request-observation port reports one request per cycle. Each request carries a valid flag, the requester's monitor ID, an access type, a read flag and a byte count. A counter that is configured with a non-zero event adds to its total for every request that matches it. Configuring event zero freezes the counter at its current value. Every command keeps a busy flag raised for a fixed two cycles and then leaves a status code.

Top module: `bwmon_unit`

## Requirements
- R1: After reset, busy is 0, status is 0, the snapshot count is 0, the snapshot overflow flag is 0 and the snapshot invalid flag is 1. No monitor counts until it is configured.
- R2: A write taken while busy is 0 holds busy at 1 for exactly two cycles. The command takes effect on the clock edge at which busy falls. A write presented while busy is 1 is ignored.
- R3: The status values are 1 for success, 2 for an opcode other than 1 or 2, and 3 for opcode 1 with an event code other than 0, 1 or 2. A failed command changes no counter state. Status changes only when busy falls.
- R4: Opcode 1 (configure) with event 1 clears the selected counter and its overflow flag and clears its invalid flag. From then on the counter adds the byte count of each matching valid request.
- R5: Opcode 1 with event 2 clears the counter in the same way. The counter then adds 1 for each matching valid request whose read flag is 1, and ignores requests whose read flag is 0.
- R6: Opcode 1 with event 0 stops the selected counter. Its value and flags stay unchanged.
- R7: A request matches a monitor when its monitor ID equals that monitor's index. When the stored access-type-valid flag is 1, the request's access type must also equal the stored access type. When that flag is 0, the access type is ignored.
- R8: Opcode 2 (read) copies the selected counter's value into the snapshot, zero-extended above the counter width, together with its overflow and invalid flags. The value copied is the one held before the completion edge. The snapshot does not change at any other time.
- R9: A counter that passes 2^CNT_W-1 wraps modulo 2^CNT_W and sets its overflow flag. The flag stays set until the counter is configured again with a non-zero event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_op | input | 5 | Opcode: 1 configure, 2 read |
| wr_mcid | input | MCID_W | Monitor ID the command targets |
| wr_evt | input | 8 | Event code: 0 stop, 1 bytes, 2 reads |
| wr_at | input | 3 | Access type to filter on |
| wr_atv | input | 1 | Access-type filter enable |
| req_valid | input | 1 | Observed request valid |
| req_mcid | input | MCID_W | Monitor ID of the observed request |
| req_at | input | 3 | Access type of the observed request |
| req_read | input | 1 | Observed request is a read |
| req_bytes | input | BYTE_W | Byte count of the observed request |
| busy | output | 1 | Command in progress |
| status | output | 7 | Result of the last command |
| rd_count | output | SNAP_W | Snapshot of the counter value |
| rd_ovf | output | 1 | Snapshot of the overflow flag |
| rd_inv | output | 1 | Snapshot of the invalid flag |

## Verification
A wrong counter or filter state is never visible on its own. It shows up only in the next read snapshot, which is two cycles after the read command is written. For this reason every stimulus pattern ends with a read. A bad busy sequencer shows at once as a wrong busy length, or as a status that changes at the wrong time. A counter that was cleared or left running when it should not have been shows as a snapshot value that is off by a known number of requests.

// File: rtl/bwmon_pkg.sv
package bwmon_pkg;

    localparam int AT_W  = 3;
    localparam int OP_W  = 5;
    localparam int EVT_W = 8;
    localparam int ST_W  = 7;

    localparam logic [OP_W-1:0] OP_CFG_EVT = 5'd1;
    localparam logic [OP_W-1:0] OP_RD_CNT  = 5'd2;

    localparam logic [EVT_W-1:0] EV_OFF   = 8'd0;
    localparam logic [EVT_W-1:0] EV_BYTES = 8'd1;
    localparam logic [EVT_W-1:0] EV_READS = 8'd2;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE    = 7'd0,
        ST_OK      = 7'd1,
        ST_BAD_OP  = 7'd2,
        ST_BAD_EVT = 7'd3
    } status_e;

    typedef struct packed {
        logic [EVT_W-1:0] evt;
        logic             atv;
        logic [AT_W-1:0]  at;
    } evt_cfg_t;

    function automatic logic evt_legal(input logic [EVT_W-1:0] e);
        return (e == EV_OFF) || (e == EV_BYTES) || (e == EV_READS);
    endfunction

endpackage

// File: rtl/bwmon_ctrl.sv
module bwmon_ctrl
    import bwmon_pkg::*;
#(
    parameter int MCID_W = 2,
    parameter bit AT_EN  = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [OP_W-1:0]          wr_op,
    input  logic [MCID_W-1:0]        wr_mcid,
    input  logic [EVT_W-1:0]         wr_evt,
    input  logic [AT_W-1:0]          wr_at,
    input  logic                     wr_atv,
    output logic                     busy,
    output logic [ST_W-1:0]          status,
    output logic                     fire_cfg,
    output logic                     fire_rd,
    output logic [MCID_W-1:0]        fire_mcid,
    output evt_cfg_t                 fire_data
);

    logic              busy_q;
    logic              phase_q;
    logic [OP_W-1:0]   op_q;
    logic [MCID_W-1:0] mcid_q;
    evt_cfg_t          cfg_q;
    status_e           status_q;
    status_e           result;
    logic              done;
    logic              is_cfg;
    logic              is_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            phase_q  <= 1'b0;
            op_q     <= '0;
            mcid_q   <= '0;
            cfg_q    <= '0;
            status_q <= ST_IDLE;
        end else if (!busy_q) begin
            if (wr_en) begin
                busy_q    <= 1'b1;
                phase_q   <= 1'b0;
                op_q      <= wr_op;
                mcid_q    <= wr_mcid;
                cfg_q.evt <= wr_evt;
                cfg_q.atv <= AT_EN ? wr_atv : 1'b0;
                cfg_q.at  <= AT_EN ? wr_at : '0;
            end
        end else if (!phase_q) begin
            phase_q <= 1'b1;
        end else begin
            busy_q   <= 1'b0;
            phase_q  <= 1'b0;
            status_q <= result;
        end
    end

    always_comb begin
        done   = busy_q && phase_q;
        is_cfg = (op_q == OP_CFG_EVT);
        is_rd  = (op_q == OP_RD_CNT);
        if (is_cfg)
            result = evt_legal(cfg_q.evt) ? ST_OK : ST_BAD_EVT;
        else if (is_rd)
            result = ST_OK;
        else
            result = ST_BAD_OP;
        fire_cfg  = done && is_cfg && evt_legal(cfg_q.evt);
        fire_rd   = done && is_rd;
        fire_mcid = mcid_q;
        fire_data = cfg_q;
    end

    assign busy   = busy_q;
    assign status = status_q;

endmodule

// File: rtl/bwmon_slot.sv
module bwmon_slot
    import bwmon_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  evt_cfg_t          cfg_in,
    input  logic              req_sel,
    input  logic [AT_W-1:0]   req_at,
    input  logic              req_read,
    input  logic [BYTE_W-1:0] req_bytes,
    output logic [CNT_W-1:0]  count,
    output logic              ovf,
    output logic              inv
);

    evt_cfg_t          cfg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ovf_q;
    logic              inv_q;
    logic              hit;
    logic [CNT_W-1:0]  incr;
    logic [CNT_W:0]    sum;

    always_comb begin
        hit = req_sel
           && (cfg_q.evt != EV_OFF)
           && (!cfg_q.atv || (req_at == cfg_q.at))
           && ((cfg_q.evt == EV_BYTES) || req_read);
        incr = (cfg_q.evt == EV_BYTES) ? CNT_W'(req_bytes) : CNT_W'(1);
        sum  = {1'b0, cnt_q} + {1'b0, incr};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
            inv_q <= 1'b1;
        end else if (cfg_we) begin
            cfg_q <= cfg_in;
            if (cfg_in.evt != EV_OFF) begin
                cnt_q <= '0;
                ovf_q <= 1'b0;
                inv_q <= 1'b0;
            end
        end else if (hit) begin
            cnt_q <= sum[CNT_W-1:0];
            if (sum[CNT_W])
                ovf_q <= 1'b1;
        end
    end

    assign count = cnt_q;
    assign ovf   = ovf_q;
    assign inv   = inv_q;

endmodule

// File: rtl/bwmon_unit.sv
module bwmon_unit
    import bwmon_pkg::*;
#(
    parameter int MCID_W = 2,
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    parameter int SNAP_W = 24,
    parameter bit AT_EN  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [4:0]        wr_op,
    input  logic [MCID_W-1:0] wr_mcid,
    input  logic [7:0]        wr_evt,
    input  logic [2:0]        wr_at,
    input  logic              wr_atv,
    input  logic              req_valid,
    input  logic [MCID_W-1:0] req_mcid,
    input  logic [2:0]        req_at,
    input  logic              req_read,
    input  logic [BYTE_W-1:0] req_bytes,
    output logic              busy,
    output logic [6:0]        status,
    output logic [SNAP_W-1:0] rd_count,
    output logic              rd_ovf,
    output logic              rd_inv
);

    localparam int NUM_MON = 1 << MCID_W;

    logic              fire_cfg;
    logic              fire_rd;
    logic [MCID_W-1:0] fire_mcid;
    evt_cfg_t          fire_data;

    logic [CNT_W-1:0]  slot_cnt [NUM_MON];
    logic              slot_ovf [NUM_MON];
    logic              slot_inv [NUM_MON];

    logic [SNAP_W-1:0] snap_cnt_q;
    logic              snap_ovf_q;
    logic              snap_inv_q;

    bwmon_ctrl #(.MCID_W(MCID_W), .AT_EN(AT_EN)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_op     (wr_op),
        .wr_mcid   (wr_mcid),
        .wr_evt    (wr_evt),
        .wr_at     (wr_at),
        .wr_atv    (wr_atv),
        .busy      (busy),
        .status    (status),
        .fire_cfg  (fire_cfg),
        .fire_rd   (fire_rd),
        .fire_mcid (fire_mcid),
        .fire_data (fire_data)
    );

    for (genvar g = 0; g < NUM_MON; g++) begin : g_slot
        bwmon_slot #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (fire_cfg && (fire_mcid == MCID_W'(g))),
            .cfg_in    (fire_data),
            .req_sel   (req_valid && (req_mcid == MCID_W'(g))),
            .req_at    (req_at),
            .req_read  (req_read),
            .req_bytes (req_bytes),
            .count     (slot_cnt[g]),
            .ovf       (slot_ovf[g]),
            .inv       (slot_inv[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_cnt_q <= '0;
            snap_ovf_q <= 1'b0;
            snap_inv_q <= 1'b1;
        end else if (fire_rd) begin
            snap_cnt_q <= SNAP_W'(slot_cnt[fire_mcid]);
            snap_ovf_q <= slot_ovf[fire_mcid];
            snap_inv_q <= slot_inv[fire_mcid];
        end
    end

    assign rd_count = snap_cnt_q;
    assign rd_ovf   = snap_ovf_q;
    assign rd_inv   = snap_inv_q;

endmodule

// File: rtl/bwmon_checker.sv
module bwmon_checker #(
    parameter int CNT_W  = 16,
    parameter int SNAP_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              busy,
    input logic [6:0]        status,
    input logic [SNAP_W-1:0] rd_count,
    input logic              rd_ovf,
    input logic              rd_inv
);

    p_wr_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_en) |=> busy);

    p_busy_second_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);

    p_busy_end_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |=> !busy);

    p_status_code_r3: assert property (@(posedge clk) disable iff (rst)
        status < 7'd4);

    p_status_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !$fell(busy) |-> $stable(status));

    p_snap_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(rd_count) && $stable(rd_ovf) && $stable(rd_inv)));

    p_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_count >> CNT_W) == '0);

endmodule

bind bwmon_unit bwmon_checker #(.CNT_W(CNT_W), .SNAP_W(SNAP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .busy     (busy),
    .status   (status),
    .rd_count (rd_count),
    .rd_ovf   (rd_ovf),
    .rd_inv   (rd_inv)
);

// File: tb/bwmon_unit_test.sv
module bwmon_unit_test;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_op = '0;
    logic [1:0]  wr_mcid = '0;
    logic [7:0]  wr_evt = '0;
    logic [2:0]  wr_at = '0;
    logic        wr_atv = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_mcid = '0;
    logic [2:0]  req_at = '0;
    logic        req_read = 1'b0;
    logic [7:0]  req_bytes = '0;
    logic        busy;
    logic [6:0]  status;
    logic [23:0] rd_count;
    logic        rd_ovf;
    logic        rd_inv;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bwmon_unit uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_op(wr_op), .wr_mcid(wr_mcid),
        .wr_evt(wr_evt), .wr_at(wr_at), .wr_atv(wr_atv), .req_valid(req_valid),
        .req_mcid(req_mcid), .req_at(req_at), .req_read(req_read),
        .req_bytes(req_bytes), .busy(busy), .status(status),
        .rd_count(rd_count), .rd_ovf(rd_ovf), .rd_inv(rd_inv)
    );

    always #(CLK_NS/2) clk = ~clk;

    typedef struct packed {
        logic [1:0]  mcid;
        logic [7:0]  evt;
        logic        atv;
        logic [2:0]  at;
        logic [1:0]  rmcid;
        logic [2:0]  rat;
        logic        rread;
        logic [7:0]  rbytes;
        logic [7:0]  reps;
        logic [15:0] expv;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 8'd1, 1'b0, 3'd0, 2'd0, 3'd5, 1'b0, 8'd10,  8'd3, 16'd30},
        '{2'd1, 8'd2, 1'b0, 3'd0, 2'd1, 3'd2, 1'b1, 8'd99,  8'd4, 16'd4},
        '{2'd1, 8'd2, 1'b0, 3'd0, 2'd1, 3'd2, 1'b0, 8'd99,  8'd4, 16'd0},
        '{2'd2, 8'd1, 1'b1, 3'd3, 2'd2, 3'd3, 1'b0, 8'd7,   8'd5, 16'd35},
        '{2'd2, 8'd1, 1'b1, 3'd3, 2'd2, 3'd4, 1'b0, 8'd7,   8'd5, 16'd0},
        '{2'd3, 8'd1, 1'b0, 3'd0, 2'd0, 3'd0, 1'b0, 8'd9,   8'd3, 16'd0},
        '{2'd3, 8'd1, 1'b1, 3'd1, 2'd3, 3'd1, 1'b1, 8'd255, 8'd2, 16'd510},
        '{2'd0, 8'd2, 1'b1, 3'd6, 2'd0, 3'd6, 1'b1, 8'd1,   8'd6, 16'd6}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic put_word(input logic [4:0] op, input logic [1:0] m, input logic [7:0] e,
                            input logic [2:0] at, input logic atv);
        @(negedge clk);
        wr_en = 1'b1; wr_op = op; wr_mcid = m; wr_evt = e; wr_at = at; wr_atv = atv;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic command(input logic [4:0] op, input logic [1:0] m, input logic [7:0] e,
                           input logic [2:0] at, input logic atv);
        put_word(op, m, e, at, atv);
        repeat (2) @(negedge clk);
    endtask

    task automatic send(input logic [1:0] m, input logic [2:0] at, input logic rd,
                        input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b1; req_mcid = m; req_at = at; req_read = rd; req_bytes = b;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 busy", busy, 0);
        check("R1 status", status, 0);
        check("R1 count", rd_count, 0);
        check("R1 inv", rd_inv, 1);
        check("R1 ovf", rd_ovf, 0);

        // R1: an unconfigured monitor does not count
        send(2'd0, 3'd0, 1'b1, 8'd50, 3);
        command(5'd2, 2'd0, 8'd0, 3'd0, 1'b0);
        check("R1 idle count", rd_count, 0);
        check("R1 idle inv", rd_inv, 1);

        // R2: busy lasts exactly two cycles
        @(negedge clk);
        wr_en = 1'b1; wr_op = 5'd1; wr_mcid = 2'd1; wr_evt = 8'd1; wr_at = '0; wr_atv = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        check("R2 busy cycle1", busy, 1);
        @(negedge clk);
        check("R2 busy cycle2", busy, 1);
        // R2: a read command presented while busy is ignored
        wr_en = 1'b1; wr_op = 5'd2; wr_mcid = 2'd0;
        @(negedge clk);
        wr_en = 1'b0;
        check("R2 busy drop", busy, 0);
        check("R2 status", status, 1);
        @(negedge clk);
        check("R2 ignored write busy", busy, 0);
        check("R2 ignored write inv", rd_inv, 1);

        // R4, R3: monitor 1 counts bytes, then an illegal event changes nothing
        send(2'd1, 3'd0, 1'b0, 8'd4, 2);
        command(5'd1, 2'd1, 8'd9, 3'd0, 1'b0);
        check("R3 bad event status", status, 3);
        send(2'd1, 3'd0, 1'b0, 8'd4, 1);
        command(5'd2, 2'd1, 8'd0, 3'd0, 1'b0);
        check("R3 config kept", rd_count, 12);
        check("R4 inv cleared", rd_inv, 0);
        command(5'd5, 2'd1, 8'd1, 3'd0, 1'b0);
        check("R3 bad op status", status, 2);
        command(5'd2, 2'd1, 8'd0, 3'd0, 1'b0);
        check("R3 bad op no effect", rd_count, 12);

        // R6: event 0 freezes the counter
        command(5'd1, 2'd1, 8'd0, 3'd0, 1'b0);
        send(2'd1, 3'd0, 1'b1, 8'd4, 3);
        command(5'd2, 2'd1, 8'd0, 3'd0, 1'b0);
        check("R6 frozen count", rd_count, 12);
        check("R6 inv kept", rd_inv, 0);

        // R4 R5 R7: vector table
        for (int v = 0; v < NVEC; v++) begin
            command(5'd1, VECS[v].mcid, VECS[v].evt, VECS[v].at, VECS[v].atv);
            send(VECS[v].rmcid, VECS[v].rat, VECS[v].rread, VECS[v].rbytes, int'(VECS[v].reps));
            command(5'd2, VECS[v].mcid, 8'd0, 3'd0, 1'b0);
            check($sformatf("R4 R5 R7 vector %0d count", v), rd_count, 32'(VECS[v].expv));
            check($sformatf("R8 vector %0d ovf", v), rd_ovf, 0);
            check($sformatf("R8 vector %0d inv", v), rd_inv, 0);
        end

        // R9: wrap and sticky overflow, R8 upper snapshot bits stay zero
        command(5'd1, 2'd2, 8'd1, 3'd0, 1'b0);
        send(2'd2, 3'd0, 1'b0, 8'd255, 258);
        command(5'd2, 2'd2, 8'd0, 3'd0, 1'b0);
        check("R9 wrapped count", rd_count, 254);
        check("R9 ovf set", rd_ovf, 1);
        check("R8 upper bits", 32'(rd_count[23:16]), 0);
        send(2'd2, 3'd0, 1'b0, 8'd1, 1);
        command(5'd2, 2'd2, 8'd0, 3'd0, 1'b0);
        check("R9 ovf sticky", rd_ovf, 1);
        check("R9 count after", rd_count, 255);
        command(5'd1, 2'd2, 8'd2, 3'd0, 1'b0);
        command(5'd2, 2'd2, 8'd0, 3'd0, 1'b0);
        check("R9 ovf cleared", rd_ovf, 0);
        check("R9 count cleared", rd_count, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule